// File: doc/BRIEF.md
# Video Port Wait-State Generator

This block sits beside an 8-bit CPU and watches its I/O bus cycles. When the CPU reads or writes one of the video display processor's ports, the block can hold the CPU by enabling a pull-down on the active-low WAIT line. The line is never driven high: the single output is the enable of an open-drain pull-down. Every other bus cycle passes through untouched.

Software chooses the behaviour by writing a control port. Wait insertion can be off, for example while the beam is in vertical blanking. It can stretch every video access by a fixed 0 to 4 wait states. It can also track the video chip's service time. In that tracking mode, each video access starts a service window when it completes. The window is counted on a reference tick that is independent of the CPU clock, so it keeps its length in real time when the CPU is overclocked. A later video access is held only while that window is still running, and is released when it ends.

Top module: `vid_wait_gen`

## Requirements
- R1: Only I/O reads or writes with address[7:2] == 6'b100110 (ports 0x98 to 0x9B) can cause wait states. Other addresses, and interrupt-acknowledge cycles (IORQ and M1 both low), never produce any.
- R2: In fixed mode with count N (0 to 4), the pull-down is enabled from the first rising edge at which a video read or write is seen. It stays enabled for exactly N clock cycles, so N = 0 gives none.
- R3: A fixed count field above 4 behaves as 4.
- R4: Mode 00 (off) and the reserved mode 11 never produce wait states.
- R5: In tracking mode, a video access that starts after the service window has run out, or before any window has been started, gets no wait state.
- R6: In tracking mode, a video access that starts while the window is running is held until the window ends. The window is loaded when a video access ends (rising edge of IORQ). Its length is (bits[7:5] + 1) reference ticks, where a tick is a rising edge of the reference input.
- R7: A write to the control port at 0x9F sets fixed count = bits[2:0], mode = bits[4:3] (00 off, 01 fixed, 10 tracking), and window = bits[7:5]. The write itself gets no wait states, and the new setting applies from the next bus cycle.
- R8: After reset, the pull-down is released, the mode is off and no window is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 8 | Low byte of the CPU address bus |
| data_i | input | 8 | CPU data bus, sampled on control port writes |
| iorq_ni | input | 1 | Active-low I/O request |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| m1_ni | input | 1 | Active-low opcode-fetch / interrupt-acknowledge marker |
| ref_clk_i | input | 1 | Reference clock from an independent 1 MHz source; each rising edge is one tick |
| wait_pull_o | output | 1 | When high, the open-drain driver pulls WAIT low |

## Verification
The case that is hardest to reach is an access that arrives while a tracking window is still running, and the same window length expiring before a later access. The bench runs the reference clock on its own period, much slower than the CPU clock. It places accesses either directly behind a completed video cycle or after a chosen idle gap. It programs the shortest and longest windows so that the same 200-cycle gap lands outside the first and inside the second. A window left over from an earlier cycle is always allowed to drain before a new tracking case starts.

// File: rtl/vwg_pkg.sv
package vwg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_FIX  = 2'b01,
    MODE_BUSY = 2'b10,
    MODE_RSV  = 2'b11
  } vwg_mode_e;
endpackage

// File: rtl/vwg_bus_decode.sv
module vwg_bus_decode #(
  parameter int          ADDR_W   = 8,
  parameter int          VID_LSB  = 2,
  parameter logic [7:0]  VID_BASE = 8'h98,
  parameter logic [7:0]  CTL_ADDR = 8'h9F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  output logic              start_vid_o,
  output logic              start_ctl_wr_o,
  output logic              act_vid_o,
  output logic              end_vid_o
);
  localparam int HI = ADDR_W - 1;

  logic act_q, act_d;
  logic vid_q, vid_d;
  logic req, start, vid_hit, ctl_hit;

  always_comb begin
    vid_hit = (addr_i[HI:VID_LSB] == VID_BASE[HI:VID_LSB]);
    ctl_hit = (addr_i == CTL_ADDR[HI:0]);
    req     = !iorq_ni && m1_ni && (!rd_ni || !wr_ni);
    start   = req && !act_q;
  end

  always_comb begin
    act_d = act_q;
    vid_d = vid_q;
    if (start) begin
      act_d = 1'b1;
      vid_d = vid_hit;
    end else if (iorq_ni) begin
      act_d = 1'b0;
      vid_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      vid_q <= 1'b0;
    end else begin
      act_q <= act_d;
      vid_q <= vid_d;
    end
  end

  assign start_vid_o    = start && vid_hit;
  assign start_ctl_wr_o = start && ctl_hit && !wr_ni;
  assign act_vid_o      = act_q && vid_q;
  assign end_vid_o      = act_q && vid_q && iorq_ni;

  AST_INTACK_NO_VIDEO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_ni && !act_q) |=> !act_vid_o); // R1
endmodule

// File: rtl/vwg_ctrl_reg.sv
module vwg_ctrl_reg
  import vwg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 3,
  parameter int MAX_FIX = 4,
  parameter int WFLD_W  = 3,
  parameter int WIN_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  output vwg_mode_e         mode_o,
  output logic [CNT_W-1:0]  fix_n_o,
  output logic [WIN_W-1:0]  win_len_o
);
  localparam int MODE_LSB = CNT_W;
  localparam int WIN_LSB  = CNT_W + 2;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  fix_raw;
  logic [WFLD_W-1:0] win_raw;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  always_comb begin
    fix_raw   = ctrl_q[CNT_W-1:0];
    win_raw   = ctrl_q[WIN_LSB +: WFLD_W];
    mode_o    = vwg_mode_e'(ctrl_q[MODE_LSB +: 2]);
    fix_n_o   = (int'(fix_raw) > MAX_FIX) ? CNT_W'(MAX_FIX) : fix_raw;
    win_len_o = WIN_W'(win_raw) + WIN_W'(1);
  end

  AST_CTL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q)); // R7
endmodule

// File: rtl/vwg_fixed_stretch.sv
module vwg_fixed_stretch
  import vwg_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int MAX_FIX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vwg_mode_e        mode_i,
  input  logic [CNT_W-1:0] fix_n_i,
  input  logic             start_vid_i,
  input  logic             end_vid_i,
  output logic             wait_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (start_vid_i && mode_i == MODE_FIX) cnt_d = fix_n_i;
    else if (end_vid_i)                    cnt_d = '0;
    else if (cnt_q != '0)                  cnt_d = cnt_q - 1'b1;
    else                                   cnt_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wait_o = (cnt_q != '0);

  AST_FIX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_FIX); // R3
  AST_FIX_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !end_vid_i && !start_vid_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/vwg_busy_window.sv
module vwg_busy_window
  import vwg_pkg::*;
#(
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  vwg_mode_e        mode_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             act_vid_i,
  input  logic             end_vid_i,
  output logic             win_run_o,
  output logic             wait_o
);
  localparam logic [WIN_W-1:0] WIN_MAX = {WIN_W{1'b1}};

  logic [SYNC_STAGES:0] sync_q;
  logic                 tick;
  logic [WIN_W-1:0]     win_q, win_d;
  logic                 load, win_en;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= ref_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign tick = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
  assign load = end_vid_i && (mode_i == MODE_BUSY);

  always_comb begin
    win_en = 1'b1;
    win_d  = win_q;
    if (load)                     win_d = win_len_i;
    else if (tick && win_q != '0) win_d = win_q - 1'b1;
    else                          win_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign win_run_o = (win_q != '0);
  assign wait_o    = (mode_i == MODE_BUSY) && act_vid_i && win_run_o;

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= WIN_MAX); // R6
  AST_WIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !tick) |=> $stable(win_q)); // R6
endmodule

// File: rtl/vid_wait_gen.sv
module vid_wait_gen
  import vwg_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  VID_BASE    = 8'h98,
  parameter int          VID_LSB     = 2,
  parameter logic [7:0]  CTL_ADDR    = 8'h9F,
  parameter int          MAX_FIX     = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  input  logic              ref_clk_i,
  output logic              wait_pull_o
);
  localparam int CNT_W  = $clog2(MAX_FIX + 1);
  localparam int WFLD_W = DATA_W - CNT_W - 2;
  localparam int WIN_W  = WFLD_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             start_vid, start_ctl_wr, act_vid, end_vid;
  vwg_mode_e        mode;
  logic [CNT_W-1:0] fix_n;
  logic [WIN_W-1:0] win_len;
  logic             wait_fix, wait_busy, win_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  vwg_bus_decode #(
    .ADDR_W(ADDR_W), .VID_LSB(VID_LSB), .VID_BASE(VID_BASE), .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_n), .addr_i(addr_i), .iorq_ni(iorq_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .m1_ni(m1_ni),
    .start_vid_o(start_vid), .start_ctl_wr_o(start_ctl_wr),
    .act_vid_o(act_vid), .end_vid_o(end_vid)
  );

  vwg_ctrl_reg #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_FIX(MAX_FIX), .WFLD_W(WFLD_W), .WIN_W(WIN_W)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(start_ctl_wr), .data_i(data_i),
    .mode_o(mode), .fix_n_o(fix_n), .win_len_o(win_len)
  );

  vwg_fixed_stretch #(.CNT_W(CNT_W), .MAX_FIX(MAX_FIX)) u_fix (
    .clk_i(clk_i), .rst_ni(rst_n), .mode_i(mode), .fix_n_i(fix_n),
    .start_vid_i(start_vid), .end_vid_i(end_vid), .wait_o(wait_fix)
  );

  vwg_busy_window #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_n), .ref_clk_i(ref_clk_i), .mode_i(mode),
    .win_len_i(win_len), .act_vid_i(act_vid), .end_vid_i(end_vid),
    .win_run_o(win_run), .wait_o(wait_busy)
  );

  assign wait_pull_o = wait_fix || wait_busy;

  AST_WAIT_ONLY_VIDEO: assert property (@(posedge clk_i) disable iff (!rst_n)
    wait_pull_o |-> act_vid); // R1
  AST_OFF_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == MODE_OFF || mode == MODE_RSV) |-> !wait_pull_o); // R4
  AST_IDLE_WINDOW_FREE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == MODE_BUSY && !win_run) |-> !wait_pull_o); // R5
endmodule

// File: tb/vid_wait_gen_bench.sv
`timescale 1ns/1ps
module vid_wait_gen_bench;
  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] data = 8'h00;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic       ref_clk = 1'b0;
  logic       wait_pull;

  int   checks = 0;
  int   failures = 0;
  exp_t q[$];
  int   wcnt = 0;
  bit   in_cyc = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (40) @(posedge clk);
      #1 ref_clk = ~ref_clk;
    end
  end

  vid_wait_gen u_vid_wait_gen (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .m1_ni(m1_n),
    .ref_clk_i(ref_clk), .wait_pull_o(wait_pull)
  );

  // monitor: count pulled cycles per I/O cycle, compare on cycle end
  always @(negedge clk) begin
    if (!iorq_n) begin
      in_cyc = 1;
      if (wait_pull) wcnt++;
    end else if (in_cyc) begin
      in_cyc = 0;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected bus cycle actual=%0d expected=none", "R1", wcnt);
      end else begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wcnt < e.lo || wcnt > e.hi) begin
          failures++;
          $display("FAIL %s: wait cycles actual=%0d expected=%0d..%0d", e.tag, wcnt, e.lo, e.hi);
        end
      end
      wcnt = 0;
    end
  end

  task automatic io_cyc(input logic [7:0] a, input logic [7:0] d, input bit wr,
                        input bit intack, input int lo, input int hi, input string tag);
    q.push_back('{lo, hi, tag});
    @(negedge clk);
    addr = a; data = d;
    m1_n = intack ? 1'b0 : 1'b1;
    iorq_n = 1'b0;
    if (!intack) begin
      if (wr) wr_n = 1'b0;
      else    rd_n = 1'b0;
    end
    @(negedge clk);
    while (wait_pull) @(negedge clk);
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] d);
    io_cyc(8'h9F, d, 1'b1, 1'b0, 0, 0, "R7");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    checks++;
    if (wait_pull !== 1'b0) begin
      failures++;
      $display("FAIL R8: pull after reset actual=%0b expected=0", wait_pull);
    end
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R8");      // mode off after reset
    ctl(8'h0B);                                  // fixed, N=3
    io_cyc(8'h98, 8'h11, 1, 0, 3, 3, "R2");
    io_cyc(8'h9B, 8'h00, 0, 0, 3, 3, "R1");
    io_cyc(8'h9C, 8'h00, 0, 0, 0, 0, "R1");
    io_cyc(8'h97, 8'h00, 1, 0, 0, 0, "R1");
    io_cyc(8'h98, 8'h00, 0, 1, 0, 0, "R1");      // interrupt acknowledge
    ctl(8'h08);                                  // fixed, N=0
    io_cyc(8'h99, 8'h00, 1, 0, 0, 0, "R2");
    ctl(8'h0F);                                  // fixed, field 7 -> 4
    io_cyc(8'h9A, 8'h00, 0, 0, 4, 4, "R3");
    ctl(8'h0C);                                  // fixed, N=4
    io_cyc(8'h98, 8'h00, 1, 0, 4, 4, "R2");
    ctl(8'h0A);                                  // fixed, N=2
    io_cyc(8'h98, 8'h00, 1, 0, 2, 2, "R7");
    ctl(8'h03);                                  // off
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R4");
    ctl(8'h1B);                                  // reserved mode
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R4");
    // tracking, 2 ticks
    ctl(8'h30);
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R5");      // no window yet
    io_cyc(8'h98, 8'h00, 1, 0, 1, 1000, "R6");   // right behind -> held
    idle(400);
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R5");      // window expired
    // tracking, 1 tick: 200-cycle gap is outside the window
    idle(400);
    ctl(8'h10);
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R5");
    idle(200);
    io_cyc(8'h99, 8'h00, 0, 0, 0, 0, "R6");
    // tracking, 8 ticks: 200-cycle gap is inside the window
    idle(400);
    ctl(8'hF0);
    io_cyc(8'h98, 8'h00, 1, 0, 0, 0, "R5");
    idle(200);
    io_cyc(8'h99, 8'h00, 0, 0, 1, 1000, "R6");
    io_cyc(8'h9C, 8'h00, 1, 0, 0, 0, "R1");      // other port during window
    idle(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule